// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block calibrates a UART divisor from a known character on the receive line. After software pulses the start input, the block waits for a start bit. It then measures the time from the first rising edge that follows the start bit to the fifth rising edge. On a 0x55 character, sent LSB first, these edges are exactly eight bit periods apart. The measurement uses a counter that runs from a prescaled copy of the system clock. The prescaler runs eight times slower than the normal baud base rate, so the count over eight bits equals one bit period expressed in base-rate units.

When the fifth edge arrives, the block writes the count minus one into the divisor. It then drops its busy status and raises a completion flag, which stays set until it is cleared. While busy is high, the divisor holds its previous value, and the surrounding receiver can use busy to stay idle. Software can abort a measurement or restart it.

Top module: `baud_autodetect`

## Requirements
- R1: After a start pulse, the block waits for RX low (start bit). Counting begins on the next rising edge, with the counter preloaded to 1. If the bit period is (P/8)*M system clocks, where P is the selected prescale, the stored divisor is M-1.
- R2: The fifth rising edge completes the measurement. In the next cycle, the divisor holds the result, busy is 0 and the flag is 1.
- R3: The select pair {sel_wide, sel_fast} sets the prescale P as follows: 00 gives 512, 01 gives 128, 10 gives 128 and 11 gives 32 system clocks per count.
- R4: Busy is 1 from the cycle after a start pulse until completion or abort. The divisor changes only in the cycle in which busy falls.
- R5: The flag stays at 1 until a flag_clr pulse clears it. If completion and flag_clr occur in the same cycle, the flag is set.
- R6: The counter saturates at all ones instead of wrapping. Saturation sets the sticky overflow output and makes the stored divisor all ones. A start pulse clears the overflow output.
- R7: A result above 255 leaves a non-zero upper byte in the 16-bit divisor. For example, M=300 gives 0x012B.
- R8: An abort pulse (abort, which wins over start) sets busy to 0 in the next cycle. An aborted measurement leaves the divisor unchanged and sets no flag.
- R9: A start pulse during a measurement discards the progress made so far. The block then waits for a new start bit.
- R10: RX activity while the block is not busy changes neither the divisor nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous receive line |
| start | input | 1 | Pulse that begins a calibration |
| abort | input | 1 | Pulse that cancels a calibration |
| sel_wide | input | 1 | Upper prescale select bit |
| sel_fast | input | 1 | Lower prescale select bit |
| flag_clr | input | 1 | Pulse that clears the completion flag (the dummy data read) |
| divisor | output | CNT_W (16) | Measured divisor |
| busy | output | 1 | Calibration in progress (enable status) |
| done_flag | output | 1 | Completion flag |
| ovf | output | 1 | Sticky counter saturation |

## Verification
The bound assertions check the following on every cycle:
- The divisor moves only when busy falls.
- The flag rises only at completion, and flag_clr wins unless completion happens in the same cycle.
- Abort ends busy in the next cycle.
- Overflow appears only while busy.

The numeric result can only be shown by the bench's scenarios. These cover each prescale setting, the average-bit-time arithmetic, saturation on a narrow counter, and the fact that an aborted, restarted or unarmed frame leaves the divisor untouched.

// File: rtl/baud_autodetect.sv
module baud_autodetect #(
  parameter int CNT_W    = 16,
  parameter int DIV_SLOW = 512,
  parameter int DIV_MID  = 128,
  parameter int DIV_FAST = 32,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             start,
  input  logic             abort,
  input  logic             sel_wide,
  input  logic             sel_fast,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] divisor,
  output logic             busy,
  output logic             done_flag,
  output logic             ovf
);
  localparam int PRE_W  = $clog2(DIV_SLOW);
  localparam int LAST_E = 4;

  typedef enum logic [1:0] {S_OFF, S_LOW, S_RISE, S_CNT} st_t;
  st_t st;

  logic [SYNC_N:0] rx_pipe;
  logic [PRE_W-1:0] pre, pre_lim;
  logic [CNT_W-1:0] cnt;
  logic [2:0] edges;

  wire rx_now = rx_pipe[SYNC_N-1];
  wire rise   = rx_now & ~rx_pipe[SYNC_N];
  wire tick   = (st == S_CNT) && (pre == pre_lim);
  wire finish = !abort && !start && (st == S_CNT) && rise && (edges == 3'(LAST_E));

  assign busy = (st != S_OFF);

  always_comb begin
    case ({sel_wide, sel_fast})
      2'b00:   pre_lim = PRE_W'(DIV_SLOW - 1);
      2'b11:   pre_lim = PRE_W'(DIV_FAST - 1);
      default: pre_lim = PRE_W'(DIV_MID - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_pipe <= '1;
    else        rx_pipe <= {rx_pipe[SYNC_N-1:0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      pre   <= '0;
      cnt   <= '0;
      edges <= '0;
      ovf   <= 1'b0;
    end else if (abort) begin
      st <= S_OFF;
    end else if (start) begin
      st    <= S_LOW;
      pre   <= '0;
      cnt   <= '0;
      edges <= '0;
      ovf   <= 1'b0;
    end else begin
      case (st)
        S_LOW:  if (!rx_now) st <= S_RISE;
        S_RISE: if (rise) begin
          st    <= S_CNT;
          edges <= 3'd1;
          pre   <= '0;
          cnt   <= CNT_W'(1);
        end
        S_CNT: begin
          if (rise) begin
            if (edges == 3'(LAST_E)) st <= S_OFF;
            else                     edges <= edges + 3'd1;
          end
          pre <= tick ? '0 : pre + 1'b1;
          if (tick) begin
            if (cnt == '1) ovf <= 1'b1;
            else           cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor   <= '0;
      done_flag <= 1'b0;
    end else begin
      if (finish) divisor <= ovf ? '1 : cnt - 1'b1;
      if (finish)        done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_autodetect_chk.sv
module baud_autodetect_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             abort,
  input logic             flag_clr,
  input logic [CNT_W-1:0] divisor,
  input logic             busy,
  input logic             done_flag,
  input logic             ovf
);
  AST_DIV_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divisor) |-> $fell(busy)); // R4

  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy)); // R2

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!done_flag || $fell(busy))); // R5

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy); // R8

  AST_OVF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> busy); // R6
endmodule

bind baud_autodetect baud_autodetect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .flag_clr(flag_clr),
  .divisor(divisor), .busy(busy), .done_flag(done_flag), .ovf(ovf)
);

// File: tb/baud_autodetect_tb.sv
module baud_autodetect_tb;
  logic clk = 0, rst_n = 0, rx = 1, start = 0, abort = 0;
  logic sel_wide = 1, sel_fast = 1, flag_clr = 0;
  logic [15:0] div;
  logic [7:0]  s_div;
  logic busy, flag, ovf, s_busy, s_flag, s_ovf;
  int checks = 0, errors = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  baud_autodetect u_dut (.clk, .rst_n, .rx_in(rx), .start, .abort, .sel_wide,
    .sel_fast, .flag_clr, .divisor(div), .busy, .done_flag(flag), .ovf);

  baud_autodetect #(.CNT_W(8)) u_small (.clk, .rst_n, .rx_in(rx), .start, .abort,
    .sel_wide, .sel_fast, .flag_clr, .divisor(s_div), .busy(s_busy),
    .done_flag(s_flag), .ovf(s_ovf));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  // frame of 0x55; poke: 0 none, 1 abort, 2 start, 3 mid-frame check (R4)
  task automatic frame(int b, int poke, logic [15:0] held);
    logic [9:0] bits = {1'b1, 8'h55, 1'b0};
    int c = 0;
    for (int i = 0; i < 10; i++) begin
      rx = bits[i];
      for (int k = 0; k < b; k++) begin
        if (c == 4*b) begin
          if (poke == 1) abort = 1;
          if (poke == 2) start = 1;
          if (poke == 3) begin
            chk("R4 busy mid", busy, 1);
            chk("R4 divisor held", div, held);
          end
        end
        @(negedge clk);
        abort = 0; start = 0;
        c++;
      end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 reset div", div, 0); chk("R2 reset busy", busy, 0);
    chk("R5 reset flag", flag, 0); chk("R6 reset ovf", ovf, 0);
  endtask

  task automatic t_basic;
    sel_wide = 1; sel_fast = 1;
    pulse(start);
    chk("R4 busy after start", busy, 1);
    frame(40, 0, 0);
    chk("R1 divisor", div, 9); chk("R2 busy", busy, 0); chk("R2 flag", flag, 1);
    repeat (20) @(negedge clk);
    chk("R5 flag holds", flag, 1);
    pulse(flag_clr);
    chk("R5 flag cleared", flag, 0);
  endtask

  task automatic t_prescale;
    sel_wide = 0; sel_fast = 0; pulse(start); frame(192, 0, 0);
    chk("R3 sel00", div, 2); pulse(flag_clr);
    sel_wide = 0; sel_fast = 1; pulse(start); frame(80, 0, 0);
    chk("R3 sel01", div, 4); pulse(flag_clr);
    sel_wide = 1; sel_fast = 0; pulse(start); frame(96, 0, 0);
    chk("R3 sel10", div, 5); pulse(flag_clr);
  endtask

  task automatic t_hold;
    sel_wide = 1; sel_fast = 1; pulse(start); frame(28, 3, 5);
    chk("R4 result", div, 6); pulse(flag_clr);
  endtask

  task automatic t_abort;
    pulse(start); frame(80, 1, 0);
    chk("R8 busy", busy, 0); chk("R8 divisor", div, 6); chk("R8 flag", flag, 0);
  endtask

  task automatic t_ignore;
    frame(36, 0, 0);
    chk("R10 divisor", div, 6); chk("R10 flag", flag, 0); chk("R10 busy", busy, 0);
  endtask

  task automatic t_restart;
    pulse(start); frame(36, 2, 0);
    chk("R9 still busy", busy, 1); chk("R9 flag", flag, 0); chk("R9 divisor", div, 6);
    pulse(start); frame(36, 0, 0);
    chk("R9 clean result", div, 8); pulse(flag_clr);
  endtask

  task automatic t_ovf;
    pulse(start); frame(1200, 0, 0);
    chk("R7 wide divisor", div, 16'h012B); chk("R7 upper byte", div[15:8], 1);
    chk("R6 no ovf wide", ovf, 0);
    chk("R6 narrow saturated", s_div, 8'hFF); chk("R6 narrow ovf", s_ovf, 1);
    pulse(flag_clr);
    pulse(start);
    chk("R6 ovf cleared by start", s_ovf, 0);
    frame(16, 0, 0);
    chk("R6 narrow recovers", s_div, 3); chk("R1 wide small", div, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_basic; t_prescale; t_hold; t_abort; t_ignore; t_restart; t_ovf;
    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!ended) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule